// File: doc/BRIEF.md
# Data RAM with Working-Register Window

This block is a 64-byte data store with two ways in. Its lowest eight bytes act as working registers that a 3-bit register field can name directly. Two of those registers, numbers 0 and 1, also serve as pointers. The low six bits of the chosen pointer select any byte of the whole array, including the working registers.

Each cycle the caller presents one of four operations: idle, direct write, indirect write, or decrement-and-test. Both the direct and the indirect read data are combinational views of the currently selected bytes. An indirect read-modify-write therefore fits into a single cycle: the caller reads `ind_rdata_o`, modifies the value and returns it on `wr_data_i` with the indirect-write operation. The decrement-and-test operation lowers a working register by one and raises a flag in the same cycle when the result is nonzero, so a loop counter and its branch decision take one step.

There is no state machine. The operation code plays that part and selects the write address and write data through a `unique case`. The four codes are `OP_IDLE`, `OP_WR_DIR`, `OP_WR_IND` and `OP_DEC`, and any code may follow any other in the next cycle. No operation ever leaves the block in a state of its own.

Top module: `dram_regwin`

## Requirements
- R1: After reset is released, every one of the 64 locations reads 0.
- R2: `dir_rdata_o` shows the byte at location `reg_sel_i` (0–7) combinationally, within the cycle in which `reg_sel_i` is applied.
- R3: Operation code 1 (`OP_WR_DIR`) stores `wr_data_i` at location `reg_sel_i` on the rising edge. The byte reads as the new value from the next cycle. During the write cycle it still reads as the old value.
- R4: The indirect address is the low 6 bits of working register `ptr_sel_i` (0 selects register 0, 1 selects register 1), and the top 2 bits of that register are ignored. `ind_rdata_o` shows the byte at that address combinationally.
- R5: Operation code 2 (`OP_WR_IND`) stores `wr_data_i` at the indirect address on the rising edge. This includes addresses 0–7, which makes the write visible through `dir_rdata_o`.
- R6: During an indirect-write cycle, `ind_rdata_o` shows the pre-edge content of the target, so a read-modify-write completes in one cycle.
- R7: Operation code 3 (`OP_DEC`) stores (register `reg_sel_i` − 1) mod 256 on the rising edge. `nz_flag_o` is 1 during that cycle exactly when the decremented value is nonzero.
- R8: Decrementing 0 stores 255 with `nz_flag_o` = 1. Decrementing 1 stores 0 with `nz_flag_o` = 0.
- R9: Operation code 0 (`OP_IDLE`) changes no location whatever `wr_data_i` holds. `nz_flag_o` is 0 under every code other than 3.
- R10: A write to a pointer register redirects the indirect address from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the array |
| op_i | input | 2 | Operation: 0 idle, 1 direct write, 2 indirect write, 3 decrement-and-test |
| reg_sel_i | input | 3 | Working register number for direct access and decrement |
| ptr_sel_i | input | 1 | Pointer register used for indirect access |
| wr_data_i | input | 8 | Write data for both write operations |
| dir_rdata_o | output | 8 | Content of the directly selected register |
| ind_rdata_o | output | 8 | Content of the indirectly addressed location |
| nz_flag_o | output | 1 | Decrement result is nonzero (only under code 3) |

## Verification
Read data and the nonzero flag are due in the same cycle as the inputs that select them. A stored value, including a rewritten pointer, is due from the cycle after the rising edge. The driver applies each operation on a falling edge and queues the expected outputs, which it takes from a reference byte array updated by the requirements. The monitor compares those outputs 1 ns after that falling edge, before the next rising edge. A write therefore shows up only in the item queued for the following operation, which is exactly when R3, R5, R7 and R10 require it.

// File: rtl/dram_pkg.sv
package dram_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int DEPTH_DEF  = 64;
    localparam int NREG_DEF   = 8;
    localparam int NPTR_DEF   = 2;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_WR_DIR = 2'd1,
        OP_WR_IND = 2'd2,
        OP_DEC    = 2'd3
    } op_e;

endpackage

// File: rtl/dram_array.sv
module dram_array #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_dir,
    output logic [W-1:0]  rdata_dir,
    input  logic [AW-1:0] raddr_ptr,
    output logic [W-1:0]  rdata_ptr,
    input  logic [AW-1:0] raddr_ind,
    output logic [W-1:0]  rdata_ind
);

    logic [DEPTH-1:0][W-1:0] words;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == AW'(i))) begin
                q <= wdata;
            end
        end
        assign words[i] = q;
    end

    assign rdata_dir = words[raddr_dir];
    assign rdata_ptr = words[raddr_ptr];
    assign rdata_ind = words[raddr_ind];

    // R3 R5 R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (words[$past(waddr)] == $past(wdata)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words));

endmodule

// File: rtl/regwin_addr.sv
module regwin_addr
    import dram_pkg::*;
#(
    parameter int W      = 8,
    parameter int DEPTH  = 64,
    parameter int NREG   = 8,
    parameter int NPTR   = 2,
    parameter int AW     = $clog2(DEPTH),
    parameter int RSEL_W = $clog2(NREG),
    parameter int PSEL_W = $clog2(NPTR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic [PSEL_W-1:0] ptr_sel,
    input  logic [W-1:0]      ptr_word,
    output logic [AW-1:0]     dir_addr,
    output logic [AW-1:0]     ptr_addr,
    output logic [AW-1:0]     ind_addr,
    output logic [AW-1:0]     wr_addr,
    output logic              we,
    output logic              dec_en
);

    logic unused_ptr_hi;

    assign dir_addr      = AW'(reg_sel);
    assign ptr_addr      = AW'(ptr_sel);
    assign ind_addr      = ptr_word[AW-1:0];
    assign unused_ptr_hi = ^ptr_word[W-1:AW];

    always_comb begin
        we      = 1'b0;
        dec_en  = 1'b0;
        wr_addr = dir_addr;
        unique case (op)
            OP_IDLE: begin
                we = 1'b0;
            end
            OP_WR_DIR: begin
                we      = 1'b1;
                wr_addr = dir_addr;
            end
            OP_WR_IND: begin
                we      = 1'b1;
                wr_addr = ind_addr;
            end
            OP_DEC: begin
                we      = 1'b1;
                dec_en  = 1'b1;
                wr_addr = dir_addr;
            end
        endcase
    end

    // R3 R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_DIR || op == OP_DEC) |-> (wr_addr < AW'(NREG)));

endmodule

// File: rtl/dec_test.sv
module dec_test #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] val,
    output logic [W-1:0] dec_val,
    output logic         nz
);

    assign dec_val = val - W'(1);
    assign nz      = en && (dec_val != '0);

endmodule

// File: rtl/dram_regwin.sv
module dram_regwin
    import dram_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    parameter int NREG   = NREG_DEF,
    parameter int NPTR   = NPTR_DEF,
    parameter int AW     = $clog2(DEPTH),
    parameter int RSEL_W = $clog2(NREG),
    parameter int PSEL_W = $clog2(NPTR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [RSEL_W-1:0] reg_sel_i,
    input  logic [PSEL_W-1:0] ptr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] dir_rdata_o,
    output logic [DATA_W-1:0] ind_rdata_o,
    output logic              nz_flag_o
);

    op_e               op;
    logic [AW-1:0]     dir_addr, ptr_addr, ind_addr, wr_addr;
    logic              we, dec_en;
    logic [DATA_W-1:0] ptr_word, dec_val, wdata;

    assign op = op_e'(op_i);

    regwin_addr #(
        .W(DATA_W), .DEPTH(DEPTH), .NREG(NREG), .NPTR(NPTR)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .reg_sel  (reg_sel_i),
        .ptr_sel  (ptr_sel_i),
        .ptr_word (ptr_word),
        .dir_addr (dir_addr),
        .ptr_addr (ptr_addr),
        .ind_addr (ind_addr),
        .wr_addr  (wr_addr),
        .we       (we),
        .dec_en   (dec_en)
    );

    dec_test #(.W(DATA_W)) u_dec (
        .en      (dec_en),
        .val     (dir_rdata_o),
        .dec_val (dec_val),
        .nz      (nz_flag_o)
    );

    assign wdata = dec_en ? dec_val : wr_data_i;

    dram_array #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (wr_addr),
        .wdata     (wdata),
        .raddr_dir (dir_addr),
        .rdata_dir (dir_rdata_o),
        .raddr_ptr (ptr_addr),
        .rdata_ptr (ptr_word),
        .raddr_ind (ind_addr),
        .rdata_ind (ind_rdata_o)
    );

    // R7
    dec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC) |-> (nz_flag_o == (dir_rdata_o != DATA_W'(1))));

    // R8
    dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC && dir_rdata_o == '0) |-> nz_flag_o);

    // R9
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_DEC) |-> !nz_flag_o);

endmodule

// File: tb/tb_dram_regwin.sv
`timescale 1ns/1ps
module tb_dram_regwin;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic [2:0] reg_sel_i = 3'd0;
    logic [0:0] ptr_sel_i = 1'b0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] dir_rdata_o, ind_rdata_o;
    logic       nz_flag_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        string      req;
        logic [7:0] dir;
        logic [7:0] ind;
        logic       nz;
    } item_t;

    item_t      q[$];
    logic [7:0] mdl [64];

    always #2 clk = ~clk;

    dram_regwin dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_sel_i(reg_sel_i),
        .ptr_sel_i(ptr_sel_i), .wr_data_i(wr_data_i),
        .dir_rdata_o(dir_rdata_o), .ind_rdata_o(ind_rdata_o), .nz_flag_o(nz_flag_o)
    );

    task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // driver: apply one operation, queue expected outputs, update the reference
    task automatic drive(string req, logic [1:0] op, logic [2:0] rs, logic ps, logic [7:0] wd);
        item_t      it;
        logic [5:0] ia;
        logic [7:0] dv;
        @(negedge clk);
        op_i = op; reg_sel_i = rs; ptr_sel_i = ps; wr_data_i = wd;
        ia = mdl[{5'd0, ps}][5:0];
        dv = mdl[{3'd0, rs}] - 8'd1;
        it.req = req;
        it.dir = mdl[{3'd0, rs}];
        it.ind = mdl[ia];
        it.nz  = (op == 2'd3) ? (dv != 8'd0) : 1'b0;
        q.push_back(it);
        case (op)
            2'd1: mdl[{3'd0, rs}] = wd;
            2'd2: mdl[ia] = wd;
            2'd3: mdl[{3'd0, rs}] = dv;
            default: ;
        endcase
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                cmp(it.req, "dir_rdata", dir_rdata_o, it.dir);
                cmp(it.req, "ind_rdata", ind_rdata_o, it.ind);
                cmp(it.req, "nz_flag", {7'd0, nz_flag_o}, {7'd0, it.nz});
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen directly and through both pointers
        for (int i = 0; i < 8; i++) drive("R1", 2'd0, 3'(i), 1'(i), 8'hFF);

        // R3: direct writes, old value visible during the write cycle
        for (int i = 2; i < 8; i++) drive("R3", 2'd1, 3'(i), 1'b0, 8'(8'h11 * i));
        // R2: direct reads of the written registers
        for (int i = 0; i < 8; i++) drive("R2", 2'd0, 3'(i), 1'b0, 8'h00);

        // R4: pointer 0 -> location 10, pointer 1 = C5 -> location 5 (upper bits ignored)
        drive("R4", 2'd1, 3'd0, 1'b0, 8'h0A);
        drive("R4", 2'd1, 3'd1, 1'b0, 8'hC5);
        drive("R4", 2'd0, 3'd5, 1'b0, 8'h00);
        drive("R4", 2'd0, 3'd5, 1'b1, 8'h00);

        // R5: indirect write above the window, then into working register 5
        drive("R5", 2'd2, 3'd0, 1'b0, 8'h77);
        drive("R5", 2'd2, 3'd5, 1'b1, 8'h33);
        drive("R5", 2'd0, 3'd5, 1'b0, 8'h00);

        // R6: read-modify-write through pointer 1
        drive("R6", 2'd2, 3'd5, 1'b1, 8'h34);
        drive("R6", 2'd2, 3'd5, 1'b1, 8'h35);
        drive("R6", 2'd0, 3'd5, 1'b1, 8'h00);

        // R10: move pointer 0 and read through it on the next cycle
        drive("R10", 2'd1, 3'd0, 1'b0, 8'h07);
        drive("R10", 2'd0, 3'd7, 1'b0, 8'h00);
        drive("R10", 2'd1, 3'd0, 1'b0, 8'hCA);
        drive("R10", 2'd0, 3'd0, 1'b0, 8'h00);

        // R7: loop counter 3 -> 2 -> 1 -> 0
        drive("R7", 2'd1, 3'd4, 1'b0, 8'h03);
        drive("R7", 2'd3, 3'd4, 1'b0, 8'h00);
        drive("R7", 2'd3, 3'd4, 1'b0, 8'h00);
        // R8: 1 -> 0 with flag low, then 0 -> FF with flag high
        drive("R8", 2'd3, 3'd4, 1'b0, 8'h00);
        drive("R8", 2'd3, 3'd4, 1'b0, 8'h00);
        drive("R8", 2'd0, 3'd4, 1'b0, 8'h00);

        // R9: idle with busy write data changes nothing
        for (int i = 0; i < 8; i++) drive("R9", 2'd0, 3'(i), 1'(i), 8'hA5);
        drive("R9", 2'd0, 3'd4, 1'b0, 8'h00);

        // R5: indirect fill of the upper array, then read back
        for (int a = 8; a < 64; a++) begin
            drive("R5", 2'd1, 3'd1, 1'b0, 8'(a) | 8'h40);
            drive("R5", 2'd2, 3'd0, 1'b1, 8'(a) ^ 8'h5A);
        end
        for (int a = 8; a < 64; a++) begin
            drive("R5", 2'd1, 3'd1, 1'b0, 8'(a));
            drive("R5", 2'd0, 3'd6, 1'b1, 8'h00);
        end

        @(negedge clk);
        op_i = 2'd0;
        @(negedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule